// File: doc/BRIEF.md
# Serial Configuration Register Port

This block holds the 24-bit configuration word of a power-line modem and gives a host processor access to it over a serial link that the device masters. Two level-sensitive select inputs, a register/data select and a receive/transmit select, choose one of four link modes. The two data modes belong to the modem's data path; this block only decodes them. The two register modes are served here. In register write mode the host presents bits on the transmit-data input. The block samples them on the rising edges of a serial clock it drives itself, and it commits the assembled word when the register select drops. In register read mode the block shifts the stored word out on the receive-data output.

The stored word is driven in parallel to the rest of the modem on `cfg_word`. It selects the carrier, baud rate, deviation, watchdog, timeouts, detection settings, interface mode and packet options. An 8-bit shadow checksum is taken whenever the word is committed and compared against the live word every cycle. Any mismatch raises an integrity flag. The comparison is masked while a register write session is in progress.

Top module: `cfgreg_serial_port`

## Requirements
- R1: `link_mode` equals {reg_sel, rx_tx}, with encoding 2'b00 data transmit, 2'b01 data receive, 2'b11 register read and 2'b10 register write.
- R2: After reset `cfg_word` is 24'h1342D7. That is: carrier select [2:0]=3'b111, baud [4:3]=2'b10, deviation [5]=0, watchdog [6]=1, timeout [8:7]=2'b01, detect time [10:9]=2'b01, zero-cross [11]=0, detect method [13:12]=2'b00, async interface [14]=1, clock out [16:15]=2'b10, packet rate [18:17]=2'b01, packet length [20:19]=2'b10 and [23:21]=0. After reset `ser_clk`, `rx_data` and `integrity_err` are 0.
- R3: In either register mode `ser_clk` has a period of BIT_CYCLES clock cycles. Counting from the first clock edge in a newly entered register mode, it is low for BIT_CYCLES/2 cycles and then high for BIT_CYCLES/2 cycles. In the data modes it stays low.
- R4: In register write mode `tx_data` is sampled at each edge where `ser_clk` rises, most significant bit first. It enters at bit 0 of a shift register that was loaded with the current word on entry to write mode.
- R5: When more than 24 bits are clocked in during one write session, only the last 24 form the committed word.
- R6: `cfg_word` changes only at the clock edge after the register select falls while in register write mode. Read sessions, data modes and leaving write mode through the rx/tx select (register select held high) leave it unchanged.
- R7: In register read mode `rx_data` presents bit 23 first and moves to the next lower bit at each falling edge of `ser_clk`, so it is stable across each rising edge. After bit 0 it wraps to bit 23. Outside read mode `rx_data` is 0.
- R8: `integrity_err` is 1 only when the stored word no longer matches the checksum taken at its last commit. With no corruption it stays 0, and during a write session it is forced to 0.
- R9: A write session with fewer than 24 bits commits the previous word shifted left by the bit count, with the new bits in the low positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 1 selects register access, 0 selects the data path |
| rx_tx | input | 1 | 1 selects receive/read, 0 selects transmit/write |
| tx_data | input | 1 | Serial data from the host |
| link_mode | output | 2 | Decoded link mode |
| cfg_word | output | 24 | Committed configuration word |
| ser_clk | output | 1 | Device-driven serial clock |
| rx_data | output | 1 | Serial register read data |
| integrity_err | output | 1 | 1 when the stored word is corrupted |

## Verification
A wrong bit counter phase shows at once on `ser_clk` and moves the sampling point, so a written word comes back shifted by one place at commit. The commit is visible one cycle after the register select drops. A stale or mis-loaded write shifter gives a committed word that differs from the arithmetic model of old-word-shifted-plus-new-bits. A read shifter fault shows within one bit period as a wrong `rx_data` value at mid-bit. A checksum mismatch raises `integrity_err` one cycle after a commit.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

  localparam int unsigned CFG_W = 24;
  localparam int unsigned SUM_W = 8;
  localparam int unsigned N_BYTES = CFG_W / SUM_W;

  // power-on configuration (field layout described in the brief)
  localparam logic [CFG_W-1:0] CFG_RESET = 24'h1342D7;

  typedef enum logic [1:0] {
    MODE_DTX = 2'b00,
    MODE_DRX = 2'b01,
    MODE_RWR = 2'b10,
    MODE_RRD = 2'b11
  } link_mode_e;

  // rotate-and-add so that byte swaps also change the result
  function automatic logic [SUM_W-1:0] cfg_sum(input logic [CFG_W-1:0] w);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_BYTES; i++) begin
      acc = {acc[SUM_W-2:0], acc[SUM_W-1]} + w[i*SUM_W +: SUM_W];
    end
    return acc;
  endfunction

endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
  import cfgreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       rx_tx,
  output link_mode_e mode,
  output link_mode_e mode_q,
  output logic       restart,
  output logic       reg_active,
  output logic       wr_entry,
  output logic       rd_entry,
  output logic       commit,
  output logic       in_write
);

  link_mode_e mode_n;

  assign mode       = link_mode_e'({reg_sel, rx_tx});
  assign mode_n     = mode;
  assign restart    = (mode != mode_q);
  assign reg_active = reg_sel;
  assign wr_entry   = restart && (mode == MODE_RWR);
  assign rd_entry   = restart && (mode == MODE_RRD);
  // session end: register select dropped while a write was open
  assign commit     = (mode_q == MODE_RWR) && !reg_sel;
  assign in_write   = (mode == MODE_RWR) || (mode_q == MODE_RWR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_DTX;
    end else begin
      mode_q <= mode_n;
    end
  end

  // R6: a commit is only seen when the previous mode was a write
  assert_commit_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(reg_sel) && !$past(rx_tx)));

endmodule

// File: rtl/cfg_sclk_gen.sv
module cfg_sclk_gen #(
  parameter int unsigned BIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  output logic ser_clk,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int unsigned CNT_W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(BIT_CYCLES / 2);
  localparam logic [CNT_W-1:0] RISE_C = CNT_W'(BIT_CYCLES / 2 - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             clk_q, clk_n;
  logic             run;

  assign run = active && !restart;

  always_comb begin
    if (!run) begin
      cnt_n = '0;
    end else if (cnt_q == LAST_C) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
    clk_n = active && (cnt_n >= HALF_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      clk_q <= clk_n;
    end
  end

  assign ser_clk  = clk_q;
  assign rise_evt = run && (cnt_q == RISE_C);
  assign fall_evt = run && (cnt_q == LAST_C);

  // R3: no serial clock outside the register modes
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !ser_clk);

  // R3: a fresh session always starts with the clock low
  assert_sclk_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ser_clk);

endmodule

// File: rtl/cfg_shift_path.sv
module cfg_shift_path
  import cfgreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  link_mode_e       mode,
  input  link_mode_e       mode_q,
  input  logic             wr_entry,
  input  logic             rd_entry,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             tx_data,
  input  logic [CFG_W-1:0] cur_word,
  output logic [CFG_W-1:0] wr_word,
  output logic             rx_data
);

  logic [CFG_W-1:0] wr_sh_q, wr_sh_n;
  logic [CFG_W-1:0] rd_sh_q, rd_sh_n;
  logic             wr_shift_en, rd_shift_en;

  assign wr_shift_en = (mode == MODE_RWR) && rise_evt;
  assign rd_shift_en = (mode == MODE_RRD) && fall_evt;

  always_comb begin
    wr_sh_n = wr_sh_q;
    if (wr_entry) begin
      wr_sh_n = cur_word;
    end else if (wr_shift_en) begin
      wr_sh_n = {wr_sh_q[CFG_W-2:0], tx_data};
    end
  end

  always_comb begin
    rd_sh_n = rd_sh_q;
    if (rd_entry) begin
      rd_sh_n = cur_word;
    end else if (rd_shift_en) begin
      rd_sh_n = {rd_sh_q[CFG_W-2:0], rd_sh_q[CFG_W-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sh_q <= CFG_RESET;
      rd_sh_q <= CFG_RESET;
    end else begin
      wr_sh_q <= wr_sh_n;
      rd_sh_q <= rd_sh_n;
    end
  end

  assign wr_word = wr_sh_q;
  assign rx_data = (mode_q == MODE_RRD) && rd_sh_q[CFG_W-1];

  // R4: the write shifter never moves outside a write session
  assert_wr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_RWR) |=> $stable(wr_word));

endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfgreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             in_write,
  input  logic [CFG_W-1:0] wr_word,
  output logic [CFG_W-1:0] word,
  output logic             integrity_err
);

  localparam logic [SUM_W-1:0] SUM_RESET = cfg_sum(CFG_RESET);

  logic [CFG_W-1:0] word_q, word_n;
  logic [SUM_W-1:0] sum_q, sum_n;
  logic             mismatch;

  always_comb begin
    word_n = word_q;
    sum_n  = sum_q;
    if (commit) begin
      word_n = wr_word;
      sum_n  = cfg_sum(wr_word);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= CFG_RESET;
      sum_q  <= SUM_RESET;
    end else begin
      word_q <= word_n;
      sum_q  <= sum_n;
    end
  end

  assign mismatch      = (cfg_sum(word_q) != sum_q);
  assign word          = word_q;
  assign integrity_err = !in_write && mismatch;

  // R6: the stored word moves only on a commit
  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(word));

  // R8: shadow checksum tracks every commit
  assert_intact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !integrity_err);

endmodule

// File: rtl/cfgreg_serial_port.sv
module cfgreg_serial_port
  import cfgreg_pkg::*;
#(
  parameter int unsigned BIT_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             rx_tx,
  input  logic             tx_data,
  output logic [1:0]       link_mode,
  output logic [CFG_W-1:0] cfg_word,
  output logic             ser_clk,
  output logic             rx_data,
  output logic             integrity_err
);

  link_mode_e       mode, mode_q;
  logic             restart, reg_active, wr_entry, rd_entry, commit, in_write;
  logic             rise_evt, fall_evt;
  logic [CFG_W-1:0] wr_word;
  logic [CFG_W-1:0] word;

  cfg_mode_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .rx_tx      (rx_tx),
    .mode       (mode),
    .mode_q     (mode_q),
    .restart    (restart),
    .reg_active (reg_active),
    .wr_entry   (wr_entry),
    .rd_entry   (rd_entry),
    .commit     (commit),
    .in_write   (in_write)
  );

  cfg_sclk_gen #(.BIT_CYCLES(BIT_CYCLES)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (reg_active),
    .restart  (restart),
    .ser_clk  (ser_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  cfg_shift_path u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .mode_q   (mode_q),
    .wr_entry (wr_entry),
    .rd_entry (rd_entry),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .tx_data  (tx_data),
    .cur_word (word),
    .wr_word  (wr_word),
    .rx_data  (rx_data)
  );

  cfg_store u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit        (commit),
    .in_write      (in_write),
    .wr_word       (wr_word),
    .word          (word),
    .integrity_err (integrity_err)
  );

  assign link_mode = mode;
  assign cfg_word  = word;

  // R7: read data holds while the serial clock is high
  assert_rd_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RRD && $past(mode_q) == MODE_RRD && ser_clk && $past(ser_clk))
      |-> $stable(rx_data));

endmodule

// File: tb/tb_cfgreg_serial_port.sv
module tb_cfgreg_serial_port;

  localparam int CLK_NS = 10;
  localparam int P      = 8;
  localparam int H      = P / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        rx_tx = 1'b0;
  logic        tx_data = 1'b0;
  logic [1:0]  link_mode;
  logic [23:0] cfg_word;
  logic        ser_clk;
  logic        rx_data;
  logic        integrity_err;

  int          errs = 0;
  int          checks = 0;
  logic [23:0] exp_word;

  cfgreg_serial_port #(.BIT_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rx_tx(rx_tx),
    .tx_data(tx_data), .link_mode(link_mode), .cfg_word(cfg_word),
    .ser_clk(ser_clk), .rx_data(rx_data), .integrity_err(integrity_err)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write session: n bits of val, MSB first; tag names the requirement
  task automatic wr_sess(input logic [31:0] val, input int n, input string tag);
    logic [23:0] sh;
    sh = exp_word;
    @(negedge clk);
    reg_sel = 1'b1; rx_tx = 1'b0;
    for (int k = 0; k < n; k++) begin
      tx_data = val[n-1-k];
      sh = {sh[22:0], val[n-1-k]};
      for (int j = 0; j < P; j++) begin
        @(negedge clk);
        if (k < 2) check("R3 write clock", {31'd0, ser_clk}, {31'd0, (j >= H)});
      end
    end
    check("R6 no change before commit", {8'd0, cfg_word}, {8'd0, exp_word});
    check("R8 flag masked in write", {31'd0, integrity_err}, 32'd0);
    reg_sel = 1'b0;
    @(negedge clk);
    exp_word = sh;
    check(tag, {8'd0, cfg_word}, {8'd0, exp_word});
    check("R8 intact after commit", {31'd0, integrity_err}, 32'd0);
  endtask

  task automatic rd_sess(input int nbits);
    @(negedge clk);
    reg_sel = 1'b1; rx_tx = 1'b1;
    repeat (H + 1) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      check("R7 read bit", {31'd0, rx_data}, {31'd0, exp_word[23 - (k % 24)]});
      if (k < 2) check("R3 read clock high", {31'd0, ser_clk}, 32'd1);
      repeat (P) @(negedge clk);
    end
    reg_sel = 1'b0; rx_tx = 1'b1;
    @(negedge clk);
    check("R7 low outside read", {31'd0, rx_data}, 32'd0);
    check("R6 read leaves word", {8'd0, cfg_word}, {8'd0, exp_word});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    exp_word = 24'h1342D7;
    repeat (3) @(negedge clk);
    check("R2 reset word", {8'd0, cfg_word}, 32'h1342D7);
    check("R2 reset clk", {31'd0, ser_clk}, 32'd0);
    check("R2 reset rx", {31'd0, rx_data}, 32'd0);
    check("R2 reset flag", {31'd0, integrity_err}, 32'd0);
    rst_n = 1'b1;

    // R1 mode sweep; data modes also keep the clock low (R3)
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      reg_sel = m[1]; rx_tx = m[0];
      #1 check("R1 mode decode", {30'd0, link_mode}, m);
      if (m < 2) begin
        for (int j = 0; j < 2 * P; j++) begin
          @(negedge clk);
          check("R3 idle in data mode", {31'd0, ser_clk}, 32'd0);
        end
      end
    end
    @(negedge clk);
    reg_sel = 1'b0; rx_tx = 1'b0;
    @(negedge clk);
    check("R6 empty write keeps word", {8'd0, cfg_word}, {8'd0, exp_word});

    rd_sess(26);

    for (int i = 0; i < 6; i++) begin
      logic [31:0] v;
      v = ((i + 1) * 32'h0005A3C9 ^ 32'h00A5F0F0) & 32'h00FFFFFF;
      wr_sess(v, 24, "R4 full write");
      rd_sess(24);
    end

    wr_sess(32'h2ABCDE01, 30, "R5 last 24 kept");
    rd_sess(24);
    wr_sess(32'h00000013, 5, "R9 short write");
    rd_sess(24);

    // R6: leave write by flipping rx_tx, then drop select from read
    @(negedge clk);
    reg_sel = 1'b1; rx_tx = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tx_data = ~tx_data;
      repeat (P) @(negedge clk);
    end
    rx_tx = 1'b1;
    repeat (H + 1) @(negedge clk);
    check("R7 read after aborted write", {31'd0, rx_data}, {31'd0, exp_word[23]});
    repeat (P) @(negedge clk);
    reg_sel = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R6 aborted write keeps word", {8'd0, cfg_word}, {8'd0, exp_word});
    check("R8 flag after abort", {31'd0, integrity_err}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule